// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the meeting point between a host CPU and a firmware controller. The host sees a small register window on a 32-bit bus. It has a command register, a status register, a 16-byte outbound data buffer and a 16-byte inbound data buffer. The host stages request bytes in the outbound buffer, then writes the command word. That write marks the mailbox busy and rings a one-cycle doorbell toward the controller.

The controller reads the latched command word and the outbound buffer words through its own plain port, and fills the inbound buffer. It finishes the transaction with a done strobe that carries an error flag and an 8-bit error code. Busy then drops, and the outcome appears in the status register. If the command asked for it, a one-cycle completion pulse goes to the host and a sticky flag is set in status. The host clears that flag by writing the status register.

The host bus is always ready: every write takes effect at the clock edge on which it is presented, and read data is a combinational function of the address. Neither side has back-pressure. The controller port is likewise plain strobes and indices.

Top module: `host_ctl_mailbox`

## Requirements
- R1: After reset, every stored bit is zero: no busy, error or flag bit and no pending pulse. A status read returns only the INIT_ID parameter in bits 15:8.
- R2: A host write inside 0x80..0x8F updates the outbound buffer word selected by address bits 3:2, one byte per set strobe bit. The controller reads whole words by index. Host reads of this range and of offset 0x00 return zero.
- R3: Command word layout: bits 7:0 are the opcode, bit 8 is the completion-pulse request, bits 15:12 are the transaction tag and bits 23:16 are the length. A host write to offset 0x00 while idle latches the full word, regardless of strobes. It sets busy and raises the doorbell for exactly the one cycle after the write edge.
- R4: A host write to offset 0x00 while busy is ignored. The latched command stays unchanged and no doorbell occurs.
- R5: The controller writes inbound buffer words with per-byte strobes, and the host reads them at 0x90..0x9F. Host writes to that range leave its contents unchanged.
- R6: Status word layout: bit 0 is busy, bit 1 is error, bit 2 is the completion flag, bit 3 reads 0, bits 7:4 are the tag of the latched command, bits 15:8 are INIT_ID and bits 23:16 are the error code. A done strobe while busy clears busy and loads the error bit and error code on the same edge.
- R7: The host interrupt is high for exactly one cycle, on the same edge where busy falls. It fires only if bit 8 of the latched command was set, and in that case the completion flag is set too.
- R8: A host write to offset 0x04 with bit 2 set clears the completion flag. A write with bit 2 clear changes nothing.
- R9: An accepted command clears the error bit and the error code.
- R10: A done strobe while idle has no effect on status and gives no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_addr | input | 8 | Host byte address |
| h_we | input | 1 | Host write enable |
| h_wdata | input | 32 | Host write data |
| h_strb | input | 4 | Host byte strobes |
| h_rdata | output | 32 | Host read data (combinational) |
| host_irq | output | 1 | One-cycle completion pulse to host |
| ctl_doorbell | output | 1 | One-cycle new-command pulse to controller |
| ctl_cmd | output | 32 | Latched command word |
| ctl_wb_idx | input | 2 | Outbound buffer word index |
| ctl_wb_data | output | 32 | Outbound buffer word |
| ctl_rb_we | input | 1 | Inbound buffer write enable |
| ctl_rb_idx | input | 2 | Inbound buffer word index |
| ctl_rb_data | input | 32 | Inbound buffer write data |
| ctl_rb_strb | input | 4 | Inbound buffer byte strobes |
| ctl_done | input | 1 | Transaction done strobe |
| ctl_err | input | 1 | Error flag sampled with done |
| ctl_err_code | input | 8 | Error code sampled with done |

## Verification
The bench builds the block with INIT_ID set to 8'h5A and the 16-byte buffers at their default size. The nonzero identifier makes any shift of the status fields visible in every status comparison. The default buffer size puts the first and last word of both buffers within reach, so partial strobes can be checked at both ends. Transactions are run with and without the completion request, with and without error, and with illegal command writes and stray done strobes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] CMD_OFS  = 8'h00;
  localparam logic [ADDR_W-1:0] STAT_OFS = 8'h04;
  localparam logic [ADDR_W-1:0] WB_OFS   = 8'h80;
  localparam logic [ADDR_W-1:0] RB_OFS   = 8'h90;
  localparam int IRQ_REQ_BIT = 8;
  localparam int TAG_LSB     = 12;
  localparam int ACK_BIT     = 2;
endpackage

// File: rtl/mbx_buf.sv
module mbx_buf
  import mbx_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < WORDS; w++) begin
        for (int b = 0; b < STRB_W; b++) begin
          if (wr_idx == IDX_W'(w) && wr_strb[b]) mem[w][b*8 +: 8] <= wr_data[b*8 +: 8];
        end
      end
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] stat_data,
  input  logic              done,
  input  logic              err_in,
  input  logic [7:0]        code_in,
  output logic [DATA_W-1:0] cmd_q,
  output logic              busy,
  output logic              err,
  output logic [7:0]        code,
  output logic              irq_flag,
  output logic              doorbell,
  output logic              host_irq
);
  logic accept, finish, want_irq;

  assign accept   = cmd_wr && !busy;
  assign finish   = done && busy;
  assign want_irq = finish && cmd_q[IRQ_REQ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      busy     <= 1'b0;
      err      <= 1'b0;
      code     <= '0;
      irq_flag <= 1'b0;
      doorbell <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      doorbell <= accept;
      host_irq <= want_irq;
      if (accept) begin
        cmd_q <= cmd_data;
        busy  <= 1'b1;
        err   <= 1'b0;
        code  <= '0;
      end else if (finish) begin
        busy <= 1'b0;
        err  <= err_in;
        code <= code_in;
      end
      if (want_irq) irq_flag <= 1'b1;
      else if (stat_wr && stat_data[ACK_BIT]) irq_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/host_ctl_mailbox.sv
module host_ctl_mailbox
  import mbx_pkg::*;
#(
  parameter int          BUF_BYTES = 16,
  parameter logic [7:0]  INIT_ID   = 8'h00,
  localparam int         WORDS     = BUF_BYTES / 4,
  localparam int         IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              h_we,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [STRB_W-1:0] h_strb,
  output logic [DATA_W-1:0] h_rdata,
  output logic              host_irq,
  output logic              ctl_doorbell,
  output logic [DATA_W-1:0] ctl_cmd,
  input  logic [IDX_W-1:0]  ctl_wb_idx,
  output logic [DATA_W-1:0] ctl_wb_data,
  input  logic              ctl_rb_we,
  input  logic [IDX_W-1:0]  ctl_rb_idx,
  input  logic [DATA_W-1:0] ctl_rb_data,
  input  logic [STRB_W-1:0] ctl_rb_strb,
  input  logic              ctl_done,
  input  logic              ctl_err,
  input  logic [7:0]        ctl_err_code
);
  logic              wb_hit, rb_hit, cmd_wr, stat_wr;
  logic [ADDR_W-1:0] wb_off, rb_off;
  logic [DATA_W-1:0] cmd_q, rb_rdata;
  logic              busy, err, irq_flag;
  logic [7:0]        code;

  assign wb_off  = h_addr - WB_OFS;
  assign rb_off  = h_addr - RB_OFS;
  assign wb_hit  = (h_addr >= WB_OFS) && (h_addr < WB_OFS + ADDR_W'(BUF_BYTES));
  assign rb_hit  = (h_addr >= RB_OFS) && (h_addr < RB_OFS + ADDR_W'(BUF_BYTES));
  assign cmd_wr  = h_we && (h_addr == CMD_OFS);
  assign stat_wr = h_we && (h_addr == STAT_OFS);

  mbx_buf #(.WORDS(WORDS), .IDX_W(IDX_W)) u_outbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(h_we && wb_hit), .wr_idx(wb_off[IDX_W+1:2]),
    .wr_data(h_wdata), .wr_strb(h_strb),
    .rd_idx(ctl_wb_idx), .rd_data(ctl_wb_data)
  );

  mbx_buf #(.WORDS(WORDS), .IDX_W(IDX_W)) u_inbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ctl_rb_we), .wr_idx(ctl_rb_idx),
    .wr_data(ctl_rb_data), .wr_strb(ctl_rb_strb),
    .rd_idx(rb_off[IDX_W+1:2]), .rd_data(rb_rdata)
  );

  mbx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_data(h_wdata),
    .stat_wr(stat_wr), .stat_data(h_wdata),
    .done(ctl_done), .err_in(ctl_err), .code_in(ctl_err_code),
    .cmd_q(cmd_q), .busy(busy), .err(err), .code(code),
    .irq_flag(irq_flag), .doorbell(ctl_doorbell), .host_irq(host_irq)
  );

  assign ctl_cmd = cmd_q;

  always_comb begin
    h_rdata = '0;
    if (h_addr == STAT_OFS)
      h_rdata = {8'h00, code, INIT_ID, cmd_q[TAG_LSB +: 4], 1'b0, irq_flag, err, busy};
    else if (rb_hit)
      h_rdata = rb_rdata;
  end
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk
  import mbx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              h_we,
  input logic [ADDR_W-1:0] h_addr,
  input logic              ctl_done,
  input logic              busy,
  input logic [DATA_W-1:0] cmd_q,
  input logic              irq_flag,
  input logic              ctl_doorbell,
  input logic              host_irq
);
  // R3
  doorbell_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_doorbell |-> $past(h_we && h_addr == CMD_OFS && !busy));
  // R4
  cmd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && h_we && h_addr == CMD_OFS) |=> $stable(cmd_q));
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ctl_done) |=> busy);
  // R7
  irq_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> ($fell(busy) && irq_flag));
  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);
endmodule

bind host_ctl_mailbox mbx_chk u_mbx_chk (
  .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_addr(h_addr),
  .ctl_done(ctl_done), .busy(busy), .cmd_q(cmd_q), .irq_flag(irq_flag),
  .ctl_doorbell(ctl_doorbell), .host_irq(host_irq)
);

// File: tb/tb_host_ctl_mailbox.sv
module tb_host_ctl_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  h_addr = '0;
  logic        h_we = 1'b0;
  logic [31:0] h_wdata = '0;
  logic [3:0]  h_strb = '0;
  logic [31:0] h_rdata;
  logic        host_irq, ctl_doorbell;
  logic [31:0] ctl_cmd, ctl_wb_data;
  logic [1:0]  ctl_wb_idx = '0;
  logic        ctl_rb_we = 1'b0;
  logic [1:0]  ctl_rb_idx = '0;
  logic [31:0] ctl_rb_data = '0;
  logic [3:0]  ctl_rb_strb = '0;
  logic        ctl_done = 1'b0;
  logic        ctl_err = 1'b0;
  logic [7:0]  ctl_err_code = '0;
  int total = 0;
  int bad = 0;
  bit timed_out = 0;

  always #10 clk = ~clk;

  host_ctl_mailbox #(.BUF_BYTES(16), .INIT_ID(8'h5A)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    h_addr = a; h_wdata = d; h_strb = s; h_we = 1'b1;
    @(negedge clk);
    h_we = 1'b0; h_strb = '0;
  endtask

  task automatic hrd(input string req, input logic [7:0] a, input logic [31:0] exp);
    h_addr = a;
    #1;
    chk(req, h_rdata, exp);
  endtask

  task automatic done_pulse(input logic e, input logic [7:0] c);
    @(negedge clk);
    ctl_done = 1'b1; ctl_err = e; ctl_err_code = c;
    @(negedge clk);
    ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0;
  endtask

  task automatic t_reset();
    chk("R1 doorbell", {31'b0, ctl_doorbell}, 0);
    chk("R1 irq", {31'b0, host_irq}, 0);
    chk("R1 cmd", ctl_cmd, 0);
    hrd("R1 status", 8'h04, 32'h0000_5A00);
    hrd("R1 inbuf", 8'h9C, 0);
  endtask

  task automatic t_outbuf();
    hwr(8'h80, 32'h1122_3344, 4'hF);
    hwr(8'h84, 32'hAABB_CCDD, 4'b0101);
    hwr(8'h8C, 32'h9988_7766, 4'b1000);
    ctl_wb_idx = 2'd0; #1; chk("R2 word0", ctl_wb_data, 32'h1122_3344);
    ctl_wb_idx = 2'd1; #1; chk("R2 word1 strobes", ctl_wb_data, 32'h00BB_00DD);
    ctl_wb_idx = 2'd3; #1; chk("R2 word3 strobes", ctl_wb_data, 32'h9900_0000);
    hrd("R2 outbuf unreadable", 8'h80, 0);
  endtask

  task automatic t_cmd_irq();
    hwr(8'h00, 32'h0004_31AB, 4'h0);
    chk("R3 doorbell", {31'b0, ctl_doorbell}, 1);
    chk("R3 cmd latched", ctl_cmd, 32'h0004_31AB);
    hrd("R3 busy status", 8'h04, 32'h0000_5A31);
    hrd("R2 cmd unreadable", 8'h00, 0);
    @(negedge clk);
    chk("R3 doorbell one cycle", {31'b0, ctl_doorbell}, 0);
    // R4: write while busy
    hwr(8'h00, 32'h0000_52FF, 4'hF);
    chk("R4 no doorbell", {31'b0, ctl_doorbell}, 0);
    chk("R4 cmd kept", ctl_cmd, 32'h0004_31AB);
  endtask

  task automatic t_inbuf();
    @(negedge clk);
    ctl_rb_we = 1'b1; ctl_rb_idx = 2'd0; ctl_rb_data = 32'hCAFE_F00D; ctl_rb_strb = 4'hF;
    @(negedge clk);
    ctl_rb_idx = 2'd3; ctl_rb_data = 32'h7712_3456; ctl_rb_strb = 4'b1000;
    @(negedge clk);
    ctl_rb_we = 1'b0; ctl_rb_strb = '0;
    hrd("R5 inbuf word0", 8'h90, 32'hCAFE_F00D);
    hrd("R5 inbuf word3", 8'h9C, 32'h7700_0000);
    hwr(8'h90, 32'h0BAD_0BAD, 4'hF);
    hrd("R5 host write ignored", 8'h90, 32'hCAFE_F00D);
  endtask

  task automatic t_done_irq();
    done_pulse(1'b0, 8'h00);
    chk("R7 irq pulse", {31'b0, host_irq}, 1);
    hrd("R6 done status", 8'h04, 32'h0000_5A34);
    @(negedge clk);
    chk("R7 irq one cycle", {31'b0, host_irq}, 0);
    hwr(8'h04, 32'h0000_0003, 4'hF);
    hrd("R8 no-ack write", 8'h04, 32'h0000_5A34);
    hwr(8'h04, 32'h0000_0004, 4'hF);
    hrd("R8 ack clears", 8'h04, 32'h0000_5A30);
  endtask

  task automatic t_err_noirq();
    hwr(8'h00, 32'h0000_5010, 4'hF);
    done_pulse(1'b1, 8'hE7);
    chk("R7 no irq without request", {31'b0, host_irq}, 0);
    hrd("R6 error status", 8'h04, 32'h00E7_5A52);
    @(negedge clk);
    chk("R7 still no irq", {31'b0, host_irq}, 0);
    hwr(8'h00, 32'h0000_0001, 4'hF);
    hrd("R9 error cleared", 8'h04, 32'h0000_5A01);
    done_pulse(1'b0, 8'h00);
    hrd("R6 idle status", 8'h04, 32'h0000_5A00);
  endtask

  task automatic t_idle_done();
    done_pulse(1'b1, 8'h55);
    chk("R10 no irq", {31'b0, host_irq}, 0);
    hrd("R10 status unchanged", 8'h04, 32'h0000_5A00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_outbuf();
        t_cmd_irq();
        t_inbuf();
        t_done_irq();
        t_err_noirq();
        t_idle_done();
      end
      begin
        repeat (200000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule